// File: doc/BRIEF.md
# Comparator Event Timer

This block is a register-mapped event timer. A 64-bit up-counter advances by one on every clock while the global run bit is set and holds its value otherwise. One comparator channel watches that counter. When the counter equals the channel's 64-bit target, the channel raises an interrupt. Each 64-bit quantity is reached as two 32-bit words at fixed byte offsets on a plain single-cycle register bus: address, write strobe, write data and combinational read data.

The channel signals an interrupt in one of two ways. In pulse mode it drives a one-cycle pulse. In level mode it latches a status flag that software clears by writing a one. In periodic mode the target advances by a stored period after each match, so a single setup gives a steady stream of events. A 32-bit mode narrows the match to the low word of the counter. A read-only capability word gives the counter's clock period in femtoseconds, so software can convert counts into time.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads zero except the capability word at offset 0x04, which reads the CAP_PERIOD parameter.
- R2: General configuration (0x10) bit 0 runs the counter, which then advances by exactly one per clock. While the bit is clear the counter holds its value. Bit 1 is a plain stored flag that reads back as written.
- R3: The counter words (0xF0 low, 0xF4 high) accept writes only while the counter is stopped. Writes made while it runs are ignored.
- R4: While the counter runs, a counter value equal to the comparator target (0x108 low, 0x10C high) is a match. The interrupt reacts on the clock edge that ends the match cycle.
- R5: In pulse mode (channel configuration 0x100 bit 1 clear), a match drives irq_o high for exactly one cycle, but only if the enable bit (bit 2) is set. The status word at 0x20 reads 0 in this mode.
- R6: In level mode (bit 1 set), a match sets status bit 0 at 0x20, and irq_o equals that status ANDed with bit 2. Writing 1 to status bit 0 clears it. Writing 0 leaves it set.
- R7: If a match and a status clear land in the same cycle, the status ends up set.
- R8: With periodic mode on (bit 3), each match adds the stored period to the comparator target.
- R9: If bit 6 is set when a comparator word is written, the same value is also loaded into the matching word of the stored period. Any comparator write clears bit 6.
- R10: With 32-bit mode on (bit 8), only the low 32 bits of counter and target are compared, and writes to 0x10C are ignored.
- R11: Channel configuration bits 1, 2, 3, 6, 8, 14 and the routing field 13:9 read back as written. All other bits read 0.
- R12: Reading the high word, then the low word, then the high word again, and retrying whenever the two high reads differ, always recovers a consistent 64-bit count across a low-word rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register |
| wr_en_i | input | 1 | Write strobe, sampled on the clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Channel interrupt |

## Verification
Two actions can fall in the same cycle and compete for one register. The first pair is a counter match and a software write of one to the level-mode status bit. The bench arms a match a fixed number of cycles ahead and times the clear write so that it is captured on the very edge that records the match. The status must then read 1. The second pair is a periodic reload and a software write to the comparator. Here the write takes priority over the reload, and an assertion checks that whenever no write is present the reload adds exactly the stored period.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
  localparam int REG_W = 32;
  localparam int CNT_W = 64;
  localparam int NHALF = CNT_W / REG_W;
  localparam int ROUTE_W = 5;

  localparam int OFF_CAP    = 'h004;
  localparam int OFF_GCFG   = 'h010;
  localparam int OFF_STS    = 'h020;
  localparam int OFF_CNT    = 'h0F0;
  localparam int OFF_CHCFG  = 'h100;
  localparam int OFF_CMP    = 'h108;

  // channel configuration bit positions
  localparam int B_LEVEL  = 1;
  localparam int B_INTEN  = 2;
  localparam int B_PERIOD = 3;
  localparam int B_VALSET = 6;
  localparam int B_MODE32 = 8;
  localparam int B_ROUTE  = 9;
  localparam int B_BUSMSG = 14;

  typedef struct packed {
    logic               level;
    logic               int_en;
    logic               periodic;
    logic               val_set;
    logic               mode32;
    logic [ROUTE_W-1:0] route;
    logic               bus_msg;
  } chcfg_t;
endpackage

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter import evt_timer_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [NHALF-1:0] wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) cnt_d = cnt_q + 1'b1;
    else begin
      for (int h = 0; h < NHALF; h++)
        if (wr_i[h]) cnt_d[h*REG_W +: REG_W] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && wr_i == '0) |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/evt_match.sv
`timescale 1ns/1ps
module evt_match import evt_timer_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             run_i,
  input  logic             mode32_i,
  input  logic             periodic_i,
  input  logic             val_set_i,
  input  logic [NHALF-1:0] wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cmp_q, cmp_d, per_q, per_d;
  logic [NHALF-1:0] wr_ok;

  // upper words are locked in 32-bit mode
  for (genvar h = 0; h < NHALF; h++) begin : g_wr
    if (h == 0) begin : g_lo
      assign wr_ok[h] = wr_i[h];
    end else begin : g_hi
      assign wr_ok[h] = wr_i[h] && !mode32_i;
    end
  end

  assign hit_o = run_i && (mode32_i ? (cnt_i[REG_W-1:0] == cmp_q[REG_W-1:0])
                                    : (cnt_i == cmp_q));

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (|wr_i) begin
      for (int h = 0; h < NHALF; h++)
        if (wr_ok[h]) begin
          cmp_d[h*REG_W +: REG_W] = wdata_i;
          if (val_set_i) per_d[h*REG_W +: REG_W] = wdata_i;
        end
    end else if (hit_o && periodic_i) begin
      cmp_d = cmp_q + per_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cmp_q <= '0;
      per_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
    end

  assign cmp_o = cmp_q;

  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && periodic_i && wr_i == '0) |=> cmp_q == $past(cmp_q) + $past(per_q));
  p_hi_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode32_i && wr_i == '0 && !(hit_o && periodic_i))
      |=> cmp_q[CNT_W-1:REG_W] == $past(cmp_q[CNT_W-1:REG_W]));
endmodule

// File: rtl/evt_irq.sv
`timescale 1ns/1ps
module evt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic level_i,
  input  logic int_en_i,
  input  logic clr_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit_i && int_en_i && !level_i;
      if (!level_i)   sts_q <= 1'b0;
      else if (hit_i) sts_q <= 1'b1;   // set beats clear
      else if (clr_i) sts_q <= 1'b0;
    end

  assign sts_o = sts_q;
  assign irq_o = level_i ? (sts_q && int_en_i) : pulse_q;

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && level_i) |=> sts_q);
  p_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && int_en_i && !level_i) |=> (irq_o || level_i));
  p_no_sts_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_i |=> !sts_q);
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer import evt_timer_pkg::*; #(
  parameter int          ADDR_W     = 12,
  parameter logic [31:0] CAP_PERIOD = 32'd69841279
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int HALF_B = REG_W / 8;

  logic             run_q, legacy_q;
  chcfg_t           ch_q;
  logic [NHALF-1:0] wr_cnt, wr_cmp;
  logic             wr_gcfg, wr_ch, wr_sts;
  logic [CNT_W-1:0] cnt, cmp;
  logic             hit, sts;

  assign wr_gcfg = wr_en_i && addr_i == ADDR_W'(OFF_GCFG);
  assign wr_ch   = wr_en_i && addr_i == ADDR_W'(OFF_CHCFG);
  assign wr_sts  = wr_en_i && addr_i == ADDR_W'(OFF_STS);

  for (genvar h = 0; h < NHALF; h++) begin : g_dec
    assign wr_cnt[h] = wr_en_i && addr_i == ADDR_W'(OFF_CNT + h*HALF_B);
    assign wr_cmp[h] = wr_en_i && addr_i == ADDR_W'(OFF_CMP + h*HALF_B);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      run_q    <= 1'b0;
      legacy_q <= 1'b0;
      ch_q     <= '0;
    end else begin
      if (wr_gcfg) begin
        run_q    <= wdata_i[0];
        legacy_q <= wdata_i[1];
      end
      if (wr_ch) begin
        ch_q.level    <= wdata_i[B_LEVEL];
        ch_q.int_en   <= wdata_i[B_INTEN];
        ch_q.periodic <= wdata_i[B_PERIOD];
        ch_q.val_set  <= wdata_i[B_VALSET];
        ch_q.mode32   <= wdata_i[B_MODE32];
        ch_q.route    <= wdata_i[B_ROUTE +: ROUTE_W];
        ch_q.bus_msg  <= wdata_i[B_BUSMSG];
      end else if (|wr_cmp) begin
        ch_q.val_set  <= 1'b0;
      end
    end

  evt_counter u_cnt (
    .clk_i, .rst_ni,
    .en_i    (run_q),
    .wr_i    (wr_cnt),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  evt_match u_match (
    .clk_i, .rst_ni,
    .cnt_i      (cnt),
    .run_i      (run_q),
    .mode32_i   (ch_q.mode32),
    .periodic_i (ch_q.periodic),
    .val_set_i  (ch_q.val_set),
    .wr_i       (wr_cmp),
    .wdata_i    (wdata_i),
    .cmp_o      (cmp),
    .hit_o      (hit)
  );

  evt_irq u_irq (
    .clk_i, .rst_ni,
    .hit_i    (hit),
    .level_i  (ch_q.level),
    .int_en_i (ch_q.int_en),
    .clr_i    (wr_sts && wdata_i[0]),
    .sts_o    (sts),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CAP))   rdata_o = CAP_PERIOD;
    if (addr_i == ADDR_W'(OFF_GCFG))  rdata_o = {30'b0, legacy_q, run_q};
    if (addr_i == ADDR_W'(OFF_STS))   rdata_o = {31'b0, sts};
    if (addr_i == ADDR_W'(OFF_CHCFG)) begin
      rdata_o[B_LEVEL]                = ch_q.level;
      rdata_o[B_INTEN]                = ch_q.int_en;
      rdata_o[B_PERIOD]               = ch_q.periodic;
      rdata_o[B_VALSET]               = ch_q.val_set;
      rdata_o[B_MODE32]               = ch_q.mode32;
      rdata_o[B_ROUTE +: ROUTE_W]     = ch_q.route;
      rdata_o[B_BUSMSG]               = ch_q.bus_msg;
    end
    for (int h = 0; h < NHALF; h++) begin
      if (addr_i == ADDR_W'(OFF_CNT + h*HALF_B)) rdata_o = cnt[h*REG_W +: REG_W];
      if (addr_i == ADDR_W'(OFF_CMP + h*HALF_B)) rdata_o = cmp[h*REG_W +: REG_W];
    end
  end

  p_vs_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_cmp) |=> !ch_q.val_set);
  p_cnt_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && (|wr_cnt)) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  localparam logic [31:0] CAP = 32'd69841279;
  localparam logic [11:0] A_CAP = 12'h004, A_GCFG = 12'h010, A_STS = 12'h020,
                          A_CLO = 12'h0F0, A_CHI = 12'h0F4, A_CH = 12'h100,
                          A_MLO = 12'h108, A_MHI = 12'h10C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic probe_vld = 1'b0;

  typedef struct {
    logic        is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  evt_timer #(.ADDR_W(12), .CAP_PERIOD(CAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compares each probed cycle against the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (probe_vld && sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq} : rdata;
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic probe_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    probe_vld = 1'b1;
    #2 probe_vld = 1'b0;
  endtask

  task automatic probe_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    probe_vld = 1'b1;
    #2 probe_vld = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic check(input logic [63:0] act, input logic [63:0] e, input string tag);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  // stop, load counter and target, set channel, then start
  task automatic arm(input logic [63:0] c, input logic [63:0] m, input logic [31:0] cfg);
    wr(A_GCFG, 32'h0);
    wr(A_CLO, c[31:0]);
    wr(A_CHI, c[63:32]);
    wr(A_CH, cfg);
    wr(A_MLO, m[31:0]);
    wr(A_MHI, m[63:32]);
    wr(A_GCFG, 32'h1);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] h1, lo, h2;
    int tries;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    probe_rd(A_CAP, CAP, "R1 capability");
    probe_rd(A_GCFG, 0, "R1 gcfg");
    probe_rd(A_STS, 0, "R1 status");
    probe_rd(A_CLO, 0, "R1 cnt lo");
    probe_rd(A_CHI, 0, "R1 cnt hi");
    probe_rd(A_CH, 0, "R1 chcfg");
    probe_rd(A_MLO, 0, "R1 cmp lo");
    probe_rd(A_MHI, 0, "R1 cmp hi");

    // R2 legacy flag, R3 counter writes while stopped
    wr(A_GCFG, 32'h2);
    probe_rd(A_GCFG, 32'h2, "R2 legacy flag");
    wr(A_CLO, 32'h10);
    wr(A_CHI, 32'h7);
    probe_rd(A_CLO, 32'h10, "R3 cnt lo write stopped");
    probe_rd(A_CHI, 32'h7, "R3 cnt hi write stopped");

    // R2 counting, R3 write ignored while running
    wr(A_GCFG, 32'h3);
    probe_rd(A_CLO, 32'h10, "R2 step0");
    probe_rd(A_CLO, 32'h11, "R2 step1");
    probe_rd(A_CLO, 32'h12, "R2 step2");
    wr(A_CLO, 32'h0);
    probe_rd(A_CLO, 32'h14, "R3 write ignored while running");
    probe_rd(A_CHI, 32'h7, "R3 hi unchanged");
    wr(A_GCFG, 32'h2);
    probe_rd(A_CLO, 32'h17, "R2 hold a");
    probe_rd(A_CLO, 32'h17, "R2 hold b");

    // R4 R5 pulse mode
    arm(64'd100, 64'd105, 32'h4);
    for (int j = 0; j < 6; j++) probe_irq(1'b0, "R4 before match");
    probe_irq(1'b1, "R5 pulse on match");
    probe_irq(1'b0, "R5 pulse one cycle");
    probe_rd(A_STS, 0, "R5 status zero in pulse mode");

    // R5 enable clear: no interrupt
    arm(64'd200, 64'd203, 32'h0);
    for (int j = 0; j < 8; j++) probe_irq(1'b0, "R5 masked");

    // R6 level mode
    arm(64'd300, 64'd304, 32'h6);
    for (int j = 0; j < 5; j++) probe_irq(1'b0, "R6 before match");
    probe_irq(1'b1, "R6 level asserted");
    probe_rd(A_STS, 1, "R6 status set");
    wr(A_STS, 32'h0);
    probe_rd(A_STS, 1, "R6 write zero keeps status");
    probe_irq(1'b1, "R6 line held");
    wr(A_STS, 32'h1);
    probe_rd(A_STS, 0, "R6 w1c clears");
    probe_irq(1'b0, "R6 line drops");

    // R7 clear captured on the edge that records the match
    arm(64'd400, 64'd404, 32'h6);
    repeat (4) @(negedge clk);
    wr(A_STS, 32'h1);
    probe_rd(A_STS, 1, "R7 set beats clear");
    wr(A_STS, 32'h1);
    probe_rd(A_STS, 0, "R7 later clear");

    // R9 value-set loads period and self-clears; R8 periodic reload
    wr(A_GCFG, 32'h0);
    wr(A_CH, 32'h4C);
    wr(A_MLO, 32'd4);
    probe_rd(A_CH, 32'h0C, "R9 valset self-clears lo");
    wr(A_CH, 32'h4C);
    wr(A_MHI, 32'd0);
    probe_rd(A_CH, 32'h0C, "R9 valset self-clears hi");
    wr(A_CLO, 32'd0);
    wr(A_CHI, 32'd0);
    wr(A_GCFG, 32'h1);
    for (int j = 0; j < 14; j++)
      probe_irq((j == 5 || j == 9 || j == 13), "R8 periodic events");
    probe_rd(A_MLO, 32'd16, "R8 target advanced");

    // R9 plain write keeps stored period
    wr(A_GCFG, 32'h0);
    wr(A_CH, 32'h0C);
    wr(A_MLO, 32'd53);
    wr(A_CLO, 32'd50);
    wr(A_GCFG, 32'h1);
    for (int j = 0; j < 5; j++) probe_irq(j == 4, "R9 match with kept period");
    probe_rd(A_MLO, 32'd57, "R9 period unchanged");

    // R10 32-bit mode
    wr(A_GCFG, 32'h0);
    wr(A_CH, 32'h104);
    wr(A_CLO, 32'd20);
    wr(A_CHI, 32'd5);
    wr(A_MLO, 32'd23);
    wr(A_MHI, 32'd9);
    probe_rd(A_MHI, 32'd0, "R10 hi write ignored");
    wr(A_GCFG, 32'h1);
    for (int j = 0; j < 5; j++) probe_irq(j == 4, "R10 low-word match");

    // R11 channel field readback
    wr(A_GCFG, 32'h0);
    wr(A_CH, 32'hFFFF_FFFF);
    probe_rd(A_CH, 32'h7F4E, "R11 implemented bits");
    wr(A_CH, 32'h2A00);
    probe_rd(A_CH, 32'h2A00, "R11 route field");

    // R12 split read across rollover
    wr(A_CH, 32'h0);
    wr(A_CHI, 32'h0);
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_GCFG, 32'h1);
    tries = 0;
    do begin
      rd(A_CHI, h1);
      rd(A_CLO, lo);
      rd(A_CHI, h2);
      tries++;
    end while (h1 != h2 && tries < 4);
    check({h1, lo}, 64'h1_0000_0003, "R12 consistent count");
    check(64'(tries), 64'd2, "R12 retry taken");

    repeat (3) @(negedge clk);
    check(64'(sb_q.size()), 64'd0, "scoreboard drained");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule